// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Read Controller

This block runs read cycles on a bus where the low half of the address and the data share one set of bidirectional lines. The host gives it a 16-bit address and a one-clock start pulse. The block then runs three phases, T1, T2 and T3. The high address byte goes on dedicated lines and stays there for all three phases. The low address byte goes on the shared lines during T1 only, and an address-latch strobe is high for that phase.

From T2 onward the block releases the shared lines so that memory can drive them. It holds an active-low read strobe low through T2 and T3. On the clock edge that ends T3 it captures the byte on the shared lines. It hands that byte back to the host with a one-clock done pulse.

The block also contains the external-side demultiplexer. This is a latch that passes the shared lines through while the strobe is high and holds the low address byte from the strobe's falling edge. It drives its output at all times, so the full 16-bit address stays valid for the whole cycle.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset the block is idle: `alat` is 0, `rd_n` is 1, `done` is 0, and the shared lines are not driven.
- R2: A start accepted while idle raises `alat` for exactly one clock (T1). `alat` stays 0 for the following T2 and T3.
- R3: During T1 the shared lines carry `addr[7:0]`. From T2 onward the block releases them, and it never drives them while `rd_n` is 0.
- R4: `a_hi` equals `addr[15:8]` of the accepted request throughout T1, T2 and T3.
- R5: `a_lo` follows the shared lines while `alat` is 1. It holds the low address byte captured when `alat` falls, through the end of T3.
- R6: `rd_n` is 0 during T2 and T3 and 1 at every other time.
- R7: `rdata` holds the value on the shared lines at the clock edge that ends T3. `done` is 1 for exactly the one clock after T3.
- R8: A start asserted while a cycle is in progress is ignored. No further T1 follows from it.
- R9: A start asserted during the clock in which `done` is 1 is accepted, and T1 begins on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a read cycle (taken only when idle) |
| addr | input | 16 | Address for the requested read |
| rdata | output | 8 | Byte captured at the end of T3 |
| done | output | 1 | One-clock pulse when `rdata` is valid |
| a_hi | output | 8 | Dedicated high address lines |
| ad | inout | 8 | Shared low-address / data lines |
| alat | output | 1 | Address-latch strobe, high during T1 |
| rd_n | output | 1 | Active-low read strobe, low during T2 and T3 |
| a_lo | output | 8 | Demultiplexed low address from the latch |

## Verification
The checker watches several rules on every clock:
- the strobe lasts a single clock, and the read strobe follows its falling edge;
- the controller never drives the shared lines while memory may be driving them;
- the high and latched low address stay stable while the read strobe is low;
- `done` is a single-clock pulse that follows a read phase.

The bench's scenarios show what the checker cannot:
- the captured byte matches memory contents for many addresses, which depends on the latched address being correct;
- a mid-cycle start is dropped;
- a start given in the `done` clock begins the next cycle immediately;
- the reset values are correct.

// File: rtl/mbus_pkg.sv
// Package: shared phase encoding for the multiplexed-bus read controller.
// Assumes a three-phase read cycle with no wait states.
package mbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_T1   = 2'd1,
        PH_T2   = 2'd2,
        PH_T3   = 2'd3
    } phase_e;
endpackage

// File: rtl/mbus_seq.sv
// Module: mbus_seq
// Steps through IDLE -> T1 -> T2 -> T3 -> IDLE for each accepted request.
// It registers the request address and captures the data byte at the edge that ends T3.
// Assumes start is sampled only in IDLE; requests at any other time are dropped.
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ad_in,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    // Phase register: advance one phase per clock, leave IDLE only on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) phase <= PH_T1;
                PH_T1:   phase <= PH_T2;
                PH_T2:   phase <= PH_T3;
                PH_T3:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Address register: hold the request address for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (phase == PH_IDLE && start) begin
            addr_q <= addr;
        end
    end

    // Read data capture: sample the shared lines on the edge that ends T3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (phase == PH_T3) begin
            rdata <= ad_in;
        end
    end

    // Completion pulse: high for the single clock after T3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (phase == PH_T3);
        end
    end

endmodule

// File: rtl/mbus_addr_latch.sv
// Module: mbus_addr_latch
// Demultiplexer for the low address byte.
// The output follows d while the strobe is high and keeps the value sampled on the last clock edge of the strobe.
// Assumes the strobe changes only on clock edges, so a flop plus a bypass mux gives latch behaviour with no race against the bus release.
module mbus_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held;

    // Holding register: track d while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (stb) begin
            held <= d;
        end
    end

    // Output select: transparent during the strobe, held value otherwise.
    always_comb begin
        q = stb ? d : held;
    end

endmodule

// File: rtl/mbus_ctrl.sv
// Module: mbus_ctrl (top)
// Read controller for a multiplexed address/data bus, plus the low-address demultiplexer.
// It decodes the phase into the strobes and the driver enable for the shared lines.
// Assumes memory drives the shared lines only while rd_n is low.
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        addr,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    inout  wire  [DATA_W-1:0]        ad,
    output logic                     alat,
    output logic                     rd_n,
    output logic [DATA_W-1:0]        a_lo
);

    localparam int HI_W = ADDR_W - DATA_W;

    phase_e            phase;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] ad_in;
    logic              ad_oe;

    mbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .addr   (addr),
        .ad_in  (ad_in),
        .phase  (phase),
        .addr_q (addr_q),
        .rdata  (rdata),
        .done   (done)
    );

    // Strobe decode: latch strobe in T1, read strobe low in T2 and T3.
    always_comb begin
        alat  = (phase == PH_T1);
        rd_n  = !((phase == PH_T2) || (phase == PH_T3));
        ad_oe = (phase == PH_T1);
        a_hi  = addr_q[ADDR_W-1:DATA_W];
    end

    // Shared-line driver: low address byte in T1, released otherwise.
    assign ad    = ad_oe ? addr_q[DATA_W-1:0] : {DATA_W{1'bz}};
    assign ad_in = ad;

    mbus_addr_latch #(
        .W (DATA_W)
    ) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (alat),
        .d     (ad_in),
        .q     (a_lo)
    );

endmodule

// File: rtl/mbus_ctrl_chk.sv
// Module: mbus_ctrl_chk
// Protocol checker bound to mbus_ctrl; observes only, drives nothing.
module mbus_ctrl_chk #(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alat,
    input logic            rd_n,
    input logic            ad_oe,
    input logic            done,
    input logic [HI_W-1:0] a_hi,
    input logic [LO_W-1:0] a_lo
);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alat |=> !alat);

    assert_bus_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_hi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(rst_n)) |-> $stable(a_hi));

    assert_lo_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(rst_n)) |-> $stable(a_lo));

    assert_read_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alat) |-> !rd_n);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(!rd_n) && rd_n));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> !alat);

endmodule

bind mbus_ctrl mbus_ctrl_chk #(
    .HI_W (ADDR_W - DATA_W),
    .LO_W (DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .alat  (alat),
    .rd_n  (rd_n),
    .ad_oe (ad_oe),
    .done  (done),
    .a_hi  (a_hi),
    .a_lo  (a_lo)
);

// File: tb/tb_mbus_ctrl.sv
// Scoreboard bench for mbus_ctrl. The driver pushes the expected address and byte; the monitor checks at negedges.
module tb_mbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  rdata, a_hi, a_lo;
    logic        done, alat, rd_n;
    wire  [7:0]  ad;

    int checks = 0;
    int errors = 0;
    bit done_prev = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_of(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // Memory model: answers from the demultiplexed address while the read strobe is low.
    assign ad = (!rd_n) ? mem_of({a_hi, a_lo}) : 8'bz;

    mbus_ctrl dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .addr  (addr),
        .rdata (rdata),
        .done  (done),
        .a_hi  (a_hi),
        .ad    (ad),
        .alat  (alat),
        .rd_n  (rd_n),
        .a_lo  (a_lo)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare bus activity and results against the scoreboard front.
    always @(negedge clk) begin
        if (rst_n) begin
            if (alat) begin
                check(sb.size() > 0, "R8 unexpected T1", 32'(sb.size()), 1);
                if (sb.size() > 0) begin
                    check(ad == sb[0].a[7:0], "R3 T1 bus", 32'(ad), 32'(sb[0].a[7:0]));
                    check(a_lo == sb[0].a[7:0], "R5 transparent", 32'(a_lo), 32'(sb[0].a[7:0]));
                    check(a_hi == sb[0].a[15:8], "R4 T1", 32'(a_hi), 32'(sb[0].a[15:8]));
                    check(rd_n == 1'b1, "R6 T1", 32'(rd_n), 1);
                end
            end
            if (!rd_n && sb.size() > 0) begin
                check(a_hi == sb[0].a[15:8], "R4 T2/T3", 32'(a_hi), 32'(sb[0].a[15:8]));
                check(a_lo == sb[0].a[7:0], "R5 held", 32'(a_lo), 32'(sb[0].a[7:0]));
            end
            if (done) begin
                check(!done_prev, "R7 pulse width", 32'(done_prev), 0);
                check(rd_n == 1'b1, "R6 after T3", 32'(rd_n), 1);
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rdata == e.d, "R7 rdata", 32'(rdata), 32'(e.d));
                end else begin
                    check(1'b0, "R7 done without request", 1, 0);
                end
            end
            done_prev = done;
        end
    end

    // Driver: request one read, optionally check T1 began at once (R9), then wait for done.
    task automatic read_cyc(input logic [15:0] a, input bit chk_r9);
        exp_t e;
        e.a = a;
        e.d = mem_of(a);
        sb.push_back(e);
        start = 1'b1;
        addr  = a;
        @(posedge clk) #2;
        start = 1'b0;
        check(alat == 1'b1, chk_r9 ? "R9 back-to-back T1" : "R2 T1 strobe", 32'(alat), 1);
        @(posedge clk) #2;
        check(alat == 1'b0 && rd_n == 1'b0, "R2 strobe low in T2", 32'({alat, rd_n}), 0);
        while (!done) @(posedge clk) #2;
    endtask

    // Driver: read with a start intruding during T2 and T3 that must be dropped.
    task automatic read_with_intruder(input logic [15:0] a, input logic [15:0] other);
        exp_t e;
        e.a = a;
        e.d = mem_of(a);
        sb.push_back(e);
        start = 1'b1;
        addr  = a;
        @(posedge clk) #2;
        start = 1'b0;
        @(posedge clk) #2;
        start = 1'b1;
        addr  = other;
        @(posedge clk) #2;
        @(posedge clk) #2;
        start = 1'b0;
        while (!done) @(posedge clk) #2;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk) #2;
            check(alat == 1'b0 && rd_n == 1'b1, "R8 no new cycle", 32'({alat, rd_n}), 1);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual %0d expected 0", sb.size());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        check(alat == 1'b0, "R1 alat", 32'(alat), 0);
        check(rd_n == 1'b1, "R1 rd_n", 32'(rd_n), 1);
        check(done == 1'b0, "R1 done", 32'(done), 0);
        rst_n = 1'b1;
        @(posedge clk) #2;
        check(alat == 1'b0 && rd_n == 1'b1, "R1 idle after reset", 32'({alat, rd_n}), 1);

        read_cyc(16'h0000, 1'b0);
        @(posedge clk) #2;
        read_cyc(16'hFFFF, 1'b0);
        @(posedge clk) #2;
        read_cyc(16'h1234, 1'b0);
        @(posedge clk) #2;
        read_cyc(16'hA55A, 1'b0);
        @(posedge clk) #2;

        // Back-to-back: start given in the done clock (R9).
        read_cyc(16'h00FF, 1'b0);
        read_cyc(16'hFF00, 1'b1);
        read_cyc(16'h8001, 1'b1);
        @(posedge clk) #2;

        // Mid-cycle start ignored (R8).
        read_with_intruder(16'h3C3C, 16'hC3C3);

        for (int k = 0; k < 8; k++) begin
            read_cyc(16'(k * 16'h1357 + 16'h0101), 1'b0);
            @(posedge clk) #2;
        end

        repeat (3) @(posedge clk);
        #2;
        check(sb.size() == 0, "R7 all results returned", 32'(sb.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule